// File: doc/BRIEF.md
# Reordered-Pipeline Hazard and Forwarding Unit

This block controls hazards for a five-stage in-order integer pipeline in which the data-memory stage sits ahead of the ALU: fetch, decode, memory, execute, writeback. A load or store uses the unmodified contents of its base register as the address, so any displacement must be computed by a separate add placed earlier in the program. Because memory comes first, an ALU result consumed as an address or store value forces a one-cycle stall. A load result consumed by a following ALU instruction needs no stall.

The decode stage presents the instruction it holds: a valid bit, a class code and three register fields. The unit keeps its own record of the instructions in the memory, execute and writeback stages. From these it drives a stall that holds the PC and the decode latch and places a bubble in the memory stage. It also drives mux selects for the two memory-stage operands (address and store data, also carried forward as ALU operands) and for the two execute-stage ALU operands. The register file writes in the first half of a cycle and is read in decode in the second half.

Top module: `reorder_hazard_unit`

## Requirements
- R1: While reset is asserted and in the cycle after it ends with no instruction yet in flight, stall is 0 and all four selects are 0.
- R2: Stall is 1 exactly when decode holds a valid load (class 2) or store (class 3), the memory stage holds a valid ALU instruction (class 1) with a nonzero destination, and that destination equals the base field (rs1) or, for a store only, the data field (rs2).
- R3: An ALU (class 1) or branch (class 4) instruction in decode never stalls, including directly after a load of one of its sources, and a load or store never stalls behind a load.
- R4: A memory-stage select is 1 (load data held past the memory stage) when the execute stage holds a valid load whose destination matches that operand: rs1 feeds fwd_mem_a, rs2 feeds fwd_mem_b.
- R5: A memory-stage select is 2 (writeback latch) when the writeback stage holds a matching producer and the execute stage does not. When execute holds a matching ALU producer, the younger one wins and the select stays 0, because that value is not ready yet.
- R6: An execute-stage select is 1 when the writeback stage holds a valid producer (ALU or load) whose destination matches that operand, else 0.
- R7: Register 0 never causes a stall and never produces a nonzero select.
- R8: A stall lasts one cycle. In the next cycle the memory stage is empty, both memory selects are 0, and the held instruction then enters the memory stage with select 2 toward the ALU result now in writeback.
- R9: Stores, branches and nops (class 0) are never producers, whatever their destination field holds.
- R10: An instruction whose valid bit is 0 neither stalls nor acts as a producer.
- R11: A datapath driven by the stall and selects leaves the same register and memory contents as executing the program one instruction at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_cls | input | 3 | Class: 0 nop, 1 ALU, 2 load, 3 store, 4 branch |
| id_rd | input | REG_W | Destination register of the decode instruction |
| id_rs1 | input | REG_W | First source (base address for memory ops) |
| id_rs2 | input | REG_W | Second source (store data for stores) |
| stall | output | 1 | Hold PC and decode latch, bubble into memory stage |
| fwd_mem_a | output | 2 | Memory-stage rs1 source: 0 carried, 1 load latch, 2 writeback |
| fwd_mem_b | output | 2 | Memory-stage rs2 source, same encoding |
| fwd_ex_a | output | 1 | Execute rs1 from writeback latch |
| fwd_ex_b | output | 1 | Execute rs2 from writeback latch |

## Verification
The bench goes after an ALU result feeding a load base or store data. A unit missing that stall would send a stale address and corrupt memory or the loaded register. It checks that a load feeding an ALU instruction passes without a stall; a unit copying the classic load-use rule would show one extra stall cycle. Two writers of one register ahead of a consumer test youngest-producer priority, where a wrong order forwards the older value. Register 0, invalid slots and the destination fields of stores and branches are each placed where a careless match would raise a stall or a select. Every sequence is checked against a sequential model, both for its final state and for its stall count.

// File: rtl/reorder_hazard_unit.sv
`timescale 1ns/1ps
module reorder_hazard_unit #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid,
  input  logic [2:0]       id_cls,
  input  logic [REG_W-1:0] id_rd,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  output logic             stall,
  output logic [1:0]       fwd_mem_a,
  output logic [1:0]       fwd_mem_b,
  output logic             fwd_ex_a,
  output logic             fwd_ex_b
);

  localparam logic [2:0] K_NOP    = 3'd0;
  localparam logic [2:0] K_ALU    = 3'd1;
  localparam logic [2:0] K_LOAD   = 3'd2;
  localparam logic [2:0] K_STORE  = 3'd3;
  localparam logic [2:0] K_BRANCH = 3'd4;

  localparam logic [1:0] SRC_PIPE = 2'd0;
  localparam logic [1:0] SRC_EXL  = 2'd1;
  localparam logic [1:0] SRC_WBL  = 2'd2;

  typedef struct packed {
    logic             v;
    logic [2:0]       c;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
  } slot_t;

  slot_t id_s, mem_q, ex_q, wb_q;

  assign id_s = {id_valid, id_cls, id_rd, id_rs1, id_rs2};

  function automatic logic produces(slot_t s);
    return s.v && (s.c == K_ALU || s.c == K_LOAD) && (s.rd != '0);
  endfunction

  function automatic logic uses_a(slot_t s);
    return s.v && (s.c == K_ALU || s.c == K_LOAD || s.c == K_STORE || s.c == K_BRANCH)
           && (s.rs1 != '0);
  endfunction

  function automatic logic uses_b(slot_t s);
    return s.v && (s.c == K_ALU || s.c == K_STORE || s.c == K_BRANCH) && (s.rs2 != '0);
  endfunction

  function automatic logic [1:0] mem_src(logic need, logic [REG_W-1:0] r, slot_t ex, slot_t wb);
    if (!need) return SRC_PIPE;
    if (produces(ex) && ex.rd == r) return (ex.c == K_LOAD) ? SRC_EXL : SRC_PIPE;
    if (produces(wb) && wb.rd == r) return SRC_WBL;
    return SRC_PIPE;
  endfunction

  logic mem_op_in_id, alu_in_mem;

  assign mem_op_in_id = id_s.v && (id_s.c == K_LOAD || id_s.c == K_STORE);
  assign alu_in_mem   = produces(mem_q) && mem_q.c == K_ALU;

  assign stall = mem_op_in_id && alu_in_mem &&
                 ((uses_a(id_s) && id_s.rs1 == mem_q.rd) ||
                  (id_s.c == K_STORE && uses_b(id_s) && id_s.rs2 == mem_q.rd));

  assign fwd_mem_a = mem_src(uses_a(mem_q), mem_q.rs1, ex_q, wb_q);
  assign fwd_mem_b = mem_src(uses_b(mem_q), mem_q.rs2, ex_q, wb_q);

  assign fwd_ex_a = uses_a(ex_q) && produces(wb_q) && wb_q.rd == ex_q.rs1;
  assign fwd_ex_b = uses_b(ex_q) && produces(wb_q) && wb_q.rd == ex_q.rs2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
      ex_q  <= '0;
      wb_q  <= '0;
    end else begin
      mem_q <= stall ? '0 : id_s;
      ex_q  <= mem_q;
      wb_q  <= ex_q;
    end
  end

  p_stall_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  p_bubble_after_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fwd_mem_a == SRC_PIPE && fwd_mem_b == SRC_PIPE));

  p_stall_only_memop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (id_valid && (id_cls == K_LOAD || id_cls == K_STORE)));

  p_alu_never_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && (id_cls == K_ALU || id_cls == K_BRANCH)) |-> !stall);

  p_zero_reg_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0 && id_rs2 == '0) |-> !stall);

  p_invalid_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !stall);

  p_load_then_ex_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mem_a == SRC_EXL) |=> fwd_ex_a);

  p_load_then_ex_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_mem_b == SRC_EXL) |=> fwd_ex_b);

  p_nop_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_cls == K_NOP) |-> !stall);

endmodule

// File: tb/reorder_hazard_unit_tb.sv
`timescale 1ns/1ps
module reorder_hazard_unit_tb_top;

  localparam logic [2:0] C_NOP = 3'd0, C_ALU = 3'd1, C_LD = 3'd2, C_ST = 3'd3, C_BR = 3'd4;

  function automatic logic [20:0] mk(input logic eos, input logic [2:0] c, input logic [2:0] rd,
                                     input logic [2:0] rs1, input logic [2:0] rs2,
                                     input logic [7:0] imm);
    return {eos, c, rd, rs1, rs2, imm};
  endfunction

  localparam int N = 31;
  localparam int NSEG = 9;
  localparam logic [20:0] PROG [N] = '{
    mk(0, C_ALU, 1, 2, 3, 4),  mk(1, C_LD, 4, 1, 0, 0),
    mk(0, C_ALU, 5, 1, 0, 2),  mk(0, C_ST, 0, 2, 5, 0),  mk(1, C_LD, 6, 2, 0, 0),
    mk(0, C_LD, 1, 3, 0, 0),   mk(0, C_ALU, 2, 1, 1, 0), mk(1, C_ALU, 3, 2, 1, 1),
    mk(0, C_LD, 7, 4, 0, 0),   mk(0, C_ST, 0, 5, 7, 0),  mk(1, C_LD, 1, 5, 0, 0),
    mk(0, C_ALU, 3, 1, 2, 1),  mk(0, C_ALU, 3, 3, 3, 2), mk(0, C_ALU, 4, 3, 1, 0),
    mk(0, C_ST, 0, 6, 3, 0),   mk(1, C_LD, 2, 6, 0, 0),
    mk(0, C_ALU, 0, 1, 2, 5),  mk(0, C_LD, 5, 0, 0, 0),  mk(1, C_ALU, 6, 0, 5, 0),
    mk(0, C_ALU, 2, 7, 1, 3),  mk(0, C_NOP, 0, 0, 0, 0), mk(0, C_LD, 3, 2, 0, 0),
    mk(1, C_ALU, 1, 3, 2, 0),
    mk(0, C_BR, 1, 2, 3, 0),   mk(0, C_LD, 4, 1, 0, 0),  mk(0, C_NOP, 2, 0, 0, 0),
    mk(1, C_ST, 0, 2, 3, 0),
    mk(0, C_ALU, 1, 4, 5, 6),  mk(0, C_LD, 2, 1, 0, 0),  mk(0, C_ALU, 3, 2, 2, 0),
    mk(1, C_ST, 0, 3, 2, 0)
  };
  localparam string SEGREQ [NSEG] = '{"R2", "R2", "R3", "R4", "R5", "R7", "R5", "R9", "R2"};

  typedef struct packed {
    logic v; logic [2:0] c; logic [2:0] rd, rs1, rs2; logic [7:0] imm;
    logic [15:0] a, b, res;
  } pst_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  pst_t cur, s_mem, s_ex, s_wb;
  logic stall, fwd_ex_a, fwd_ex_b;
  logic [1:0] fwd_mem_a, fwd_mem_b;
  logic [15:0] rf [8];
  logic [15:0] dm [16];
  logic [15:0] grf [8];
  logic [15:0] gdm [16];
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  reorder_hazard_unit #(.REG_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid(cur.v), .id_cls(cur.c),
    .id_rd({2'b00, cur.rd}), .id_rs1({2'b00, cur.rs1}), .id_rs2({2'b00, cur.rs2}),
    .stall(stall), .fwd_mem_a(fwd_mem_a), .fwd_mem_b(fwd_mem_b),
    .fwd_ex_a(fwd_ex_a), .fwd_ex_b(fwd_ex_b));

  function automatic pst_t dec(input logic [20:0] w, input logic v);
    pst_t p = '0;
    p.v = v; p.c = w[19:17]; p.rd = w[16:14]; p.rs1 = w[13:11]; p.rs2 = w[10:8]; p.imm = w[7:0];
    return p;
  endfunction

  function automatic logic writer(input pst_t p);
    return p.v && (p.c == C_ALU || p.c == C_LD) && p.rd != 3'd0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input logic [1:0] sel, input logic [15:0] carried);
    case (sel)
      2'd1: return s_ex.res;
      2'd2: return s_wb.res;
      default: return carried;
    endcase
  endfunction

  task automatic step(output logic stl);
    pst_t nm, ne, nw;
    stl = stall;
    if (writer(s_wb)) rf[s_wb.rd] = s_wb.res;
    ne = s_mem;
    ne.a = pick(fwd_mem_a, s_mem.a);
    ne.b = pick(fwd_mem_b, s_mem.b);
    ne.res = 16'h0;
    if (s_mem.v && s_mem.c == C_LD) ne.res = dm[ne.a[3:0]];
    if (s_mem.v && s_mem.c == C_ST) dm[ne.a[3:0]] = ne.b;
    nw = s_ex;
    nw.a = fwd_ex_a ? s_wb.res : s_ex.a;
    nw.b = fwd_ex_b ? s_wb.res : s_ex.b;
    if (s_ex.v && s_ex.c == C_ALU) nw.res = nw.a + nw.b + 16'(s_ex.imm);
    if (stl) nm = '0;
    else begin
      nm = cur; nm.a = rf[cur.rs1]; nm.b = rf[cur.rs2]; nm.res = 16'h0;
    end
    @(posedge clk);
    s_wb = nw; s_ex = ne; s_mem = nm;
    @(negedge clk);
  endtask

  task automatic issue(input logic [20:0] w);
    logic s;
    cur = dec(w, 1'b1); #1; step(s);
  endtask

  task automatic settle_nop();
    cur = dec(mk(0, C_NOP, 0, 0, 0, 0), 1'b1); #1;
  endtask

  task automatic drain();
    logic s;
    for (int k = 0; k < 4; k++) begin settle_nop(); step(s); end
  endtask

  task automatic gold(input int lo, input int hi, output int est);
    est = 0;
    for (int i = lo; i <= hi; i++) begin
      pst_t p = dec(PROG[i], 1'b1);
      if (i > lo) begin
        pst_t q = dec(PROG[i-1], 1'b1);
        if ((p.c == C_LD || p.c == C_ST) && q.c == C_ALU && q.rd != 3'd0 &&
            (p.rs1 == q.rd || (p.c == C_ST && p.rs2 == q.rd))) est++;
      end
      case (p.c)
        C_ALU: if (p.rd != 3'd0) grf[p.rd] = grf[p.rs1] + grf[p.rs2] + 16'(p.imm);
        C_LD:  if (p.rd != 3'd0) grf[p.rd] = gdm[grf[p.rs1][3:0]];
        C_ST:  gdm[grf[p.rs1][3:0]] = grf[p.rs2];
        default: ;
      endcase
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic s;
    int pc, seg, lo, nst, est;
    bit mem_ok;
    s_mem = '0; s_ex = '0; s_wb = '0;
    cur = dec(mk(0, C_NOP, 0, 0, 0, 0), 1'b1);
    for (int i = 0; i < 8; i++) begin rf[i] = (i == 0) ? 16'h0 : 16'(i * 7 + 3); grf[i] = rf[i]; end
    for (int k = 0; k < 16; k++) begin dm[k] = 16'(k * 11 + 5); gdm[k] = dm[k]; end

    repeat (3) @(negedge clk);
    #1;
    chk("R1", "stall in reset", 32'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "mem selects after reset", {fwd_mem_a, fwd_mem_b}, 0);
    chk("R1", "ex selects after reset", {fwd_ex_a, fwd_ex_b}, 0);
    chk("R1", "stall after reset", 32'(stall), 0);

    pc = 0; seg = 0; lo = 0; nst = 0;
    while (pc < N) begin
      cur = dec(PROG[pc], 1'b1); #1;
      step(s);
      if (s) nst++;
      else begin
        if (PROG[pc][20]) begin
          drain();
          gold(lo, pc, est);
          chk(SEGREQ[seg], "stall count", nst, est);
          for (int r = 1; r < 8; r++) chk("R11", $sformatf("reg %0d", r), rf[r], grf[r]);
          mem_ok = 1'b1;
          for (int k = 0; k < 16; k++) if (dm[k] !== gdm[k]) mem_ok = 1'b0;
          chk("R11", "memory image", 32'(mem_ok), 1);
          seg++; lo = pc + 1; nst = 0;
        end
        pc++;
      end
    end

    // load data into the very next store's data operand
    drain();
    issue(mk(0, C_LD, 7, 4, 0, 0)); issue(mk(0, C_ST, 0, 5, 7, 0)); settle_nop();
    chk("R4", "store data from load latch", fwd_mem_b, 1);
    chk("R4", "store base untouched", fwd_mem_a, 0);

    // younger load beats older ALU of the same register
    drain();
    issue(mk(0, C_ALU, 3, 1, 2, 0)); issue(mk(0, C_LD, 3, 1, 0, 0));
    issue(mk(0, C_ST, 0, 5, 3, 0)); settle_nop();
    chk("R5", "youngest producer is the load", fwd_mem_b, 1);

    // writeback forwarding at distance two
    drain();
    issue(mk(0, C_ALU, 3, 1, 2, 0)); issue(mk(0, C_ALU, 4, 1, 2, 0));
    issue(mk(0, C_ST, 0, 5, 3, 0)); settle_nop();
    chk("R5", "store data from writeback", fwd_mem_b, 2);

    // younger ALU in execute masks older writeback copy
    drain();
    issue(mk(0, C_ALU, 3, 1, 2, 0)); issue(mk(0, C_ALU, 3, 1, 2, 0));
    issue(mk(0, C_ALU, 6, 3, 1, 0)); settle_nop();
    chk("R5", "older producer masked", fwd_mem_a, 0);
    step(s); settle_nop();
    chk("R6", "ex operand a from writeback", 32'(fwd_ex_a), 1);
    chk("R6", "ex operand b stays", 32'(fwd_ex_b), 0);

    // load feeding both operands of an ALU instruction
    drain();
    issue(mk(0, C_LD, 1, 4, 0, 0));
    cur = dec(mk(0, C_ALU, 2, 1, 1, 0), 1'b1); #1;
    chk("R3", "no load-use stall", 32'(stall), 0);
    step(s); settle_nop();
    chk("R4", "both mem selects from load latch", {fwd_mem_a, fwd_mem_b}, 4'b0101);
    step(s); settle_nop();
    chk("R6", "both ex selects", {fwd_ex_a, fwd_ex_b}, 2'b11);

    // ALU result used as load base
    drain();
    issue(mk(0, C_ALU, 1, 2, 3, 0));
    cur = dec(mk(0, C_LD, 4, 1, 0, 0), 1'b1); #1;
    chk("R2", "stall on ALU-to-base", 32'(stall), 1);
    step(s); #1;
    chk("R8", "stall released", 32'(stall), 0);
    chk("R8", "bubble selects", {fwd_mem_a, fwd_mem_b}, 0);
    step(s); settle_nop();
    chk("R8", "base from writeback", fwd_mem_a, 2);

    // invalid producer
    drain();
    cur = dec(mk(0, C_ALU, 1, 2, 3, 0), 1'b0); #1; step(s);
    cur = dec(mk(0, C_LD, 4, 1, 0, 0), 1'b1); #1;
    chk("R10", "invalid ALU no stall", 32'(stall), 0);
    step(s); settle_nop();
    chk("R10", "invalid ALU no select", fwd_mem_a, 0);

    // register zero
    drain();
    issue(mk(0, C_ALU, 0, 1, 2, 0));
    cur = dec(mk(0, C_ST, 0, 0, 0, 0), 1'b1); #1;
    chk("R7", "r0 no stall", 32'(stall), 0);
    step(s); settle_nop();
    chk("R7", "r0 no select", {fwd_mem_a, fwd_mem_b}, 0);

    // store destination field is not a producer
    drain();
    issue(mk(0, C_ST, 2, 5, 6, 0));
    cur = dec(mk(0, C_LD, 4, 2, 0, 0), 1'b1); #1;
    chk("R9", "store rd no stall", 32'(stall), 0);
    step(s); step(s); settle_nop();
    chk("R9", "store rd no ex select", 32'(fwd_ex_a), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule